// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and a 128K x 8 asynchronous static RAM. The host presents one read or one write at a time on a valid/ready port. The controller turns each request into a strobe sequence that meets the memory's timing minima. Those minima are given as nanosecond parameters. At elaboration they are rounded up to whole clock cycles of the system clock.

The memory has a low-active and a high-active chip enable, an active-low output enable and an active-low write enable. Its data bus is shared. The controller drives the data lines through a split output/enable/input triple, which the pad ring joins into one tristate bus.

A write holds write enable low for a computed number of cycles. The data drivers stay off for the first few of those cycles, so the memory has time to release the bus. Write enable then rises, and address and data are held one more cycle. A read holds output enable low for the full access time, then captures the bus.

A standby request parks the memory in its deepest power-down state by pulling both enables inactive. When the request is released, a recovery interval must pass before the host is served again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is active and after reset, the pins rest at idle: sram_ce1_n=1, sram_ce2=1, sram_oe_n=1, sram_we_n=1, sram_dq_oe=0, and rd_valid=0, wr_done=0. req_ready is 0 during reset and 1 within four cycles after the release.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the access ends, and during standby and recovery. A request offered while req_ready is 0 moves no memory pin.
- R3: For a write, the address register is loaded at acceptance. The address pins and the selected enables (ce1_n=0, ce2=1) then stay unchanged from the first cycle of the write-enable pulse through the hold cycle. Write enable is low for WE_CYC consecutive cycles: the largest of the rounded write-pulse time, TURN_CYC+DS_CYC, and the rounded write-cycle time minus one. This is 5 cycles at the default 10 ns clock.
- R4: sram_oe_n is 1 in every cycle in which sram_we_n is 0.
- R5: The data drivers stay off (sram_dq_oe=0) during the first TURN_CYC cycles of each write-enable pulse. TURN_CYC is the rounded bus-release time, at least 1; the default is 2.
- R6: Once switched on during a write, sram_dq_o carries the request's write data unchanged. It is driven for at least DS_CYC cycles (default 3) before write enable rises.
- R7: In the cycle after write enable rises, the chip stays selected and address and data are still driven. In the following cycle the chip is deselected, the drivers are off, and wr_done is 1 for exactly one cycle.
- R8: A read keeps the chip selected, output enable low and write enable high for RD_CYC cycles (default 5). It then samples sram_dq_i and presents the value on rd_data with a one-cycle rd_valid pulse, in the same cycle in which the chip is deselected.
- R9: In standby, sram_ce1_n=1 and sram_ce2=0 with both strobes high and the drivers off. Standby lasts as long as stby_req is held. A standby request raised during an access takes effect only after that access has completed.
- R10: After stby_req falls, req_ready stays 0 for REC_CYC cycles (default 5). During those cycles the pins sit at idle levels (ce1_n=1, ce2=1). req_ready then returns to 1.
- R11: When stby_req and req_valid are both 1 in an idle cycle, standby is taken and the request is not accepted. req_ready is 0 in every cycle where stby_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 8 | Data captured from the memory |
| wr_done | output | 1 | One-cycle pulse: write finished |
| stby_req | input | 1 | Hold high to park the memory in low-power standby |
| sram_addr | output | 17 | Memory address pins |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_o | output | 8 | Data to the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 8 | Data from the memory |

## Verification
Two things can land in the same cycle: a standby request and a host access. The bench raises stby_req and req_valid on the same idle cycle. It expects standby pins at the next edge and no strobe activity. A later read-back shows the offered write never reached the memory. It also raises stby_req in the middle of a read. The read must finish with its full output-enable window and a correct rd_valid pulse, and only then may ce2 fall.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_STBY,
    ST_RECOV
  } seq_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_IDLE = '{ce1_n: 1'b1, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             zero
);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned WE_CYC  = 5,
  parameter int unsigned RD_CYC  = 5,
  parameter int unsigned REC_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             stby_req,
  input  logic             cnt_zero,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_init,
  output logic             req_ready,
  output logic             accept,
  output logic             rd_cap,
  output logic             wr_fin
);

  localparam logic [CNT_W-1:0] WE_INIT  = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_INIT  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] REC_INIT = CNT_W'(REC_CYC - 1);

  assign req_ready = rst_n && (state_q == ST_IDLE) && !stby_req;
  assign accept    = req_ready && req_valid;
  assign rd_cap    = (state_q == ST_RACC) && cnt_zero;
  assign wr_fin    = (state_q == ST_WHOLD);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_init = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (stby_req) begin
          state_d = ST_STBY;
        end else if (req_valid) begin
          cnt_load = 1'b1;
          if (req_write) begin
            state_d  = ST_WPULSE;
            cnt_init = WE_INIT;
          end else begin
            state_d  = ST_RACC;
            cnt_init = RD_INIT;
          end
        end
      end
      ST_WPULSE: if (cnt_zero) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      ST_RACC:   if (cnt_zero) state_d = ST_IDLE;
      ST_STBY: begin
        if (!stby_req) begin
          state_d  = ST_RECOV;
          cnt_load = 1'b1;
          cnt_init = REC_INIT;
        end
      end
      ST_RECOV:  if (cnt_zero) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned WE_CYC   = 5,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_cap,
  input  logic              wr_fin,
  input  logic [DATA_W-1:0] dq_i,
  output pin_ctl_t          pins_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rd_valid_q,
  output logic              wr_done_q
);

  localparam int DRV_LAST = int'(WE_CYC) - 1 - int'(TURN_CYC);

  pin_ctl_t pins_d;

  always_comb begin
    pins_d = PINS_IDLE;
    unique case (state_d)
      ST_WPULSE: begin
        pins_d.ce1_n = 1'b0;
        pins_d.we_n  = 1'b0;
        pins_d.dq_oe = (int'(cnt_d) <= DRV_LAST);
      end
      ST_WHOLD: begin
        pins_d.ce1_n = 1'b0;
        pins_d.dq_oe = 1'b1;
      end
      ST_RACC: begin
        pins_d.ce1_n = 1'b0;
        pins_d.oe_n  = 1'b0;
      end
      ST_STBY: begin
        pins_d.ce2 = 1'b0;
      end
      default: pins_d = PINS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q     <= PINS_IDLE;
      rd_valid_q <= 1'b0;
      wr_done_q  <= 1'b0;
    end else begin
      pins_q     <= pins_d;
      rd_valid_q <= rd_cap;
      wr_done_q  <= wr_fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_cap) begin
      rdata_q <= dq_i;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_WP_NS   = 35,
  parameter int unsigned T_DS_NS   = 25,
  parameter int unsigned T_WC_NS   = 45,
  parameter int unsigned T_AA_NS   = 45,
  parameter int unsigned T_OE_NS   = 20,
  parameter int unsigned T_RC_NS   = 45,
  parameter int unsigned T_HZWE_NS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_done,
  input  logic              stby_req,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned WP_CYC   = max2(1, ns_to_cyc(T_WP_NS, CLK_NS));
  localparam int unsigned DS_CYC   = max2(1, ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int unsigned WC_CYC   = max2(2, ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int unsigned TURN_CYC = max2(1, ns_to_cyc(T_HZWE_NS, CLK_NS));
  localparam int unsigned WE_CYC   = max2(max2(WP_CYC, TURN_CYC + DS_CYC), WC_CYC - 1);
  localparam int unsigned RD_CYC   = max2(1, max2(ns_to_cyc(T_AA_NS, CLK_NS),
                                         max2(ns_to_cyc(T_OE_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS))));
  localparam int unsigned REC_CYC  = max2(1, ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned MAX_CYC  = max2(WE_CYC, max2(RD_CYC, REC_CYC));
  localparam int unsigned CNT_W    = max2(1, $clog2(MAX_CYC));

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  seq_state_e       state_q;
  seq_state_e       state_d;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_init;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_zero;
  logic             accept;
  logic             rd_cap;
  logic             wr_fin;
  pin_ctl_t         pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cnt_load),
    .load_val (cnt_init),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .zero     (cnt_zero)
  );

  asram_seq #(
    .CNT_W   (CNT_W),
    .WE_CYC  (WE_CYC),
    .RD_CYC  (RD_CYC),
    .REC_CYC (REC_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .stby_req  (stby_req),
    .cnt_zero  (cnt_zero),
    .state_q   (state_q),
    .state_d   (state_d),
    .cnt_load  (cnt_load),
    .cnt_init  (cnt_init),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_cap    (rd_cap),
    .wr_fin    (wr_fin)
  );

  asram_pins #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .WE_CYC   (WE_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .state_d    (state_d),
    .cnt_d      (cnt_d),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_cap     (rd_cap),
    .wr_fin     (wr_fin),
    .dq_i       (sram_dq_i),
    .pins_q     (pins_q),
    .addr_q     (sram_addr),
    .wdata_q    (sram_dq_o),
    .rdata_q    (rd_data),
    .rd_valid_q (rd_valid),
    .wr_done_q  (wr_done)
  );

  assign sram_ce1_n = pins_q.ce1_n;
  assign sram_ce2   = pins_q.ce2;
  assign sram_oe_n  = pins_q.oe_n;
  assign sram_we_n  = pins_q.we_n;
  assign sram_dq_oe = pins_q.dq_oe;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              stby_req,
  input logic              rd_valid,
  input logic              wr_done,
  input logic [ADDR_W-1:0] addr,
  input logic              ce1_n,
  input logic              ce2,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe
);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && ce2 && $past(!ce1_n && ce2)) |-> $stable(addr));

  p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce1_n && ce2 && oe_n));

  p_no_drive_at_we_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> !dq_oe);

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

  p_hold_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (!ce1_n && ce2 && dq_oe));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_stby_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce2 |-> (ce1_n && oe_n && we_n && !dq_oe));

  p_stby_blocks_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req |-> !req_ready);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_ready (req_ready),
  .stby_req  (stby_req),
  .rd_valid  (rd_valid),
  .wr_done   (wr_done),
  .addr      (sram_addr),
  .ce1_n     (sram_ce1_n),
  .ce2       (sram_ce2),
  .oe_n      (sram_oe_n),
  .we_n      (sram_we_n),
  .dq_o      (sram_dq_o),
  .dq_oe     (sram_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        wr_done;
  logic        stby_req = 1'b0;
  logic [16:0] sram_addr;
  logic        sram_ce1_n;
  logic        sram_ce2;
  logic        sram_oe_n;
  logic        sram_we_n;
  logic [7:0]  sram_dq_o;
  logic        sram_dq_oe;
  logic [7:0]  sram_dq_i = 8'hEE;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  asram_ctrl u_asram_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .wr_done    (wr_done),
    .stby_req   (stby_req),
    .sram_addr  (sram_addr),
    .sram_ce1_n (sram_ce1_n),
    .sram_ce2   (sram_ce2),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe),
    .sram_dq_i  (sram_dq_i)
  );

  // Memory model: write lands on the rising write-enable edge; read data
  // becomes valid only after four edges of an uninterrupted read window.
  logic [7:0] mem [logic [16:0]];
  logic       prev_we_n = 1'b1;
  int         rd_run = 0;

  always @(posedge clk) begin
    if (!sram_ce1_n && sram_ce2 && !prev_we_n && sram_we_n && sram_dq_oe)
      mem[sram_addr] = sram_dq_o;
    prev_we_n <= sram_we_n;
    if (!sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n) begin
      rd_run <= rd_run + 1;
      if (rd_run >= 3)
        sram_dq_i <= mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
      else
        sram_dq_i <= 8'hEE;
    end else begin
      rd_run    <= 0;
      sram_dq_i <= 8'hEE;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pins in reset", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b11110);
    chk("R1", "ready in reset", req_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "pins after reset", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b11110);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "pulses after reset", {rd_valid, wr_done}, 0);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    int we_low = 0, bad_sel = 0, early_drv = 0, drv_setup = 0, oe_low = 0, bad_data = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    for (int i = 0; i < 7; i++) begin
      if (!sram_we_n) we_low++;
      if (!sram_oe_n) oe_low++;
      if (i <= 5 && (sram_ce1_n || !sram_ce2 || sram_addr != a)) bad_sel++;
      if (i < 2 && sram_dq_oe) early_drv++;
      if (!sram_we_n && sram_dq_oe && sram_dq_o == d) drv_setup++;
      if (sram_dq_oe && sram_dq_o != d) bad_data++;
      if (i == 2) chk("R2", "ready during write", req_ready, 0);
      if (i == 5) begin
        chk("R7", "hold cycle we/oe/drive", {sram_we_n, sram_dq_oe, sram_ce1_n}, 3'b110);
        chk("R7", "hold cycle data", sram_dq_o, d);
        chk("R7", "no done in hold cycle", wr_done, 0);
      end
      if (i == 6) begin
        chk("R7", "released after hold", {sram_ce1_n, sram_dq_oe}, 2'b10);
        chk("R7", "done pulse", wr_done, 1);
      end
      @(negedge clk);
    end
    chk("R7", "done is one cycle", wr_done, 0);
    chk("R3", "write pulse length", we_low, 5);
    chk("R3", "address/enables held", bad_sel, 0);
    chk("R4", "oe low during write", oe_low, 0);
    chk("R5", "drive in turnaround", early_drv, 0);
    chk("R6", "driven setup cycles", drv_setup, 3);
    chk("R6", "driven data value", bad_data, 0);
  endtask

  task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
    int oe_low = 0, bad_sel = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    for (int i = 0; i < 7; i++) begin
      if (!sram_oe_n) oe_low++;
      if (i <= 4 && (sram_ce1_n || !sram_ce2 || !sram_we_n || sram_addr != a || sram_dq_oe)) bad_sel++;
      if (i == 2) chk("R2", "ready during read", req_ready, 0);
      if (i == 5) begin
        chk("R8", "rd_valid at end", rd_valid, 1);
        chk("R8", "read data", rd_data, exp);
        chk("R8", "deselect with rd_valid", sram_ce1_n, 1);
      end
      if (i == 6) chk("R8", "rd_valid one cycle", rd_valid, 0);
      @(negedge clk);
    end
    chk("R8", "oe window", oe_low, 5);
    chk("R8", "read pins held", bad_sel, 0);
  endtask

  task automatic t_standby();
    int bad = 0, rec = 0, rec_bad = 0;
    wait_ready();
    stby_req = 1'b1;
    #1;
    chk("R11", "ready drops with standby", req_ready, 0);
    @(negedge clk);
    chk("R9", "standby pins", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00123;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sram_ce2 || !sram_oe_n || !sram_we_n || rd_valid || wr_done || req_ready) bad++;
    end
    chk("R2", "requests ignored in standby", bad, 0);
    chk("R9", "standby held", sram_ce2, 0);
    req_valid = 1'b0;
    stby_req = 1'b0;
    @(negedge clk);
    while (!req_ready && rec < 50) begin
      if (!sram_ce1_n == 1'b1 || !sram_ce2) rec_bad++;
      rec++;
      @(negedge clk);
    end
    chk("R10", "recovery cycles", rec, 5);
    chk("R10", "idle pins in recovery", rec_bad, 0);
  endtask

  task automatic t_collide(input logic [16:0] a);
    int bad = 0;
    wait_ready();
    stby_req = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = 8'h99;
    @(negedge clk);
    chk("R11", "standby wins", {sram_ce1_n, sram_ce2, sram_we_n}, 3'b101);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!sram_we_n || sram_ce2) bad++;
    end
    chk("R11", "no write strobe in collision", bad, 0);
    req_valid = 1'b0; stby_req = 1'b0;
  endtask

  task automatic t_stby_mid_read(input logic [16:0] a, input logic [7:0] exp);
    int oe_low = 0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 7; i++) begin
      if (i == 1) stby_req = 1'b1;
      if (!sram_oe_n) oe_low++;
      if (i == 5) begin
        chk("R9", "read completes under standby req", rd_valid, 1);
        chk("R9", "read data under standby req", rd_data, exp);
        chk("R9", "ce2 high until read done", sram_ce2, 1);
      end
      if (i == 6) chk("R9", "standby after read", {sram_ce1_n, sram_ce2}, 2'b10);
      @(negedge clk);
    end
    chk("R9", "full oe window before standby", oe_low, 5);
    stby_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_write(17'h00000, 8'h3C);
    t_write(17'h1FFFF, 8'hC3);
    t_write(17'h0A5A5, 8'hFF);
    t_write(17'h00001, 8'h00);
    t_read(17'h00000, 8'h3C);
    t_read(17'h1FFFF, 8'hC3);
    t_read(17'h0A5A5, 8'hFF);
    t_read(17'h00001, 8'h00);
    t_write(17'h00000, 8'h81);
    t_read(17'h00000, 8'h81);
    t_standby();
    t_read(17'h0A5A5, 8'hFF);
    t_collide(17'h1FFFF);
    t_read(17'h1FFFF, 8'hC3);
    t_stby_mid_read(17'h00000, 8'h81);
    t_read(17'h00001, 8'h00);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule